// File: doc/BRIEF.md
# Bus-Mapped LED, Keyboard and Timer Peripheral

This block hangs on a shared 16-bit address bus and 8-bit data bus with a single read/write line, next to RAM and ROM. A processor reaches it with ordinary loads and stores: there is no separate I/O signalling. Inside a 128-byte window starting at 0xD000 it exposes an LED output register, a keyboard data register with a status byte, and a free-running 16-bit timer read one byte at a time.

A key event (a one-cycle strobe with an 8-bit code) is captured into the keyboard register and marks the byte as pending, which pulls the active-low interrupt output low. The interrupt handler reads the keyboard register; that read releases the interrupt. If a second code arrives before the first is collected, the newer code replaces it and a sticky overrun flag records the loss. Every clock edge is one bus cycle: the address, read/write line and write data present at the edge are acted on at that edge, and read data is returned combinationally during the cycle.

Top module: `mmio_periph`

## Requirements
- R1: `bus_rd_en` is high exactly when `bus_rw` is 1 (read) and `bus_addr` lies in 0xD000..0xD07F; otherwise it is low, and no write cycle ever drives it.
- R2: A write cycle (`bus_rw` = 0) to 0xD000 loads `bus_wdata` into the LED register, visible on `led_out` after that clock edge; `led_out[i]` follows bit i, so 0xA5 lights LEDs 7, 5, 2 and 0. Writes to any other address leave `led_out` and every readable value unchanged.
- R3: A read of offset 0x00 returns the current LED register.
- R4: A `key_stb` pulse stores `key_code`; a later read of offset 0x12 returns the stored code.
- R5: `irq_n` goes low on the edge that captures a key event and stays low until an edge at which offset 0x12 is read with no new event, after which it returns high.
- R6: A key event arriving while a byte is pending (and not read in that cycle) replaces the stored code and sets the overrun flag.
- R7: Offset 0x13 reads status with bit 0 = pending and bit 1 = overrun, other bits 0; a read of 0x13 clears the overrun flag on that edge and leaves pending unchanged.
- R8: If a key event and a read of 0x12 fall in the same cycle, the read returns the old code, the new code becomes pending, `irq_n` stays low, and no overrun is recorded.
- R9: The timer counts up by one every clock and wraps at 16 bits; offset 0x40 reads its low byte and 0x41 its high byte, both live, so consecutive low-byte reads differ by one.
- R10: Reset clears the LED register, the key register, pending and overrun, holds `irq_n` high and sets the timer to zero, so the timer equals the number of clock edges since reset ended.
- R11: A read of any other offset inside the window drives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one bus cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Address bus |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data, valid while `bus_rd_en` is high |
| bus_rd_en | output | 1 | Read data drive enable |
| key_stb | input | 1 | One-cycle key event strobe |
| key_code | input | 8 | Key code accompanying the strobe |
| led_out | output | 8 | LED drive pins, one bit per LED |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The decode is swept over all 65536 addresses as reads, which separates in-window offsets from the neighbouring space on both sides and checks the zero fill of unused offsets, and over an 8 KiB region as writes, which shows only one address touches the LEDs. All 256 LED values are written and read back so stuck or swapped bits are told apart. Key events are applied singly, back to back before collection, and on the very cycle the handler reads, which separates plain capture, overrun and the read/event race. The timer is compared against an edge count kept since reset, including across the 16-bit wrap.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
    localparam int OFF_LED  = 'h00;
    localparam int OFF_KEY  = 'h12;
    localparam int OFF_STAT = 'h13;
    localparam int OFF_TLO  = 'h40;
    localparam int OFF_THI  = 'h41;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LED,
        SEL_KEY,
        SEL_STAT,
        SEL_TLO,
        SEL_THI
    } reg_sel_e;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_BITS = 7,
    parameter logic [ADDR_W-1:0] BASE = 16'hD000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_sel_e          sel
);
    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic [TAG_W-1:0]    tag;
    logic [WIN_BITS-1:0] off;

    assign tag = addr[ADDR_W-1:WIN_BITS];
    assign off = addr[WIN_BITS-1:0];

    always_comb begin
        hit = (tag == BASE[ADDR_W-1:WIN_BITS]);
        sel = SEL_NONE;
        if (hit) begin
            if (off == WIN_BITS'(OFF_LED))       sel = SEL_LED;
            else if (off == WIN_BITS'(OFF_KEY))  sel = SEL_KEY;
            else if (off == WIN_BITS'(OFF_STAT)) sel = SEL_STAT;
            else if (off == WIN_BITS'(OFF_TLO))  sel = SEL_TLO;
            else if (off == WIN_BITS'(OFF_THI))  sel = SEL_THI;
        end
    end
endmodule

// File: rtl/mmio_keylatch.sv
module mmio_keylatch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [DATA_W-1:0] code,
    input  logic              clr_key,
    input  logic              clr_stat,
    output logic [DATA_W-1:0] key_q,
    output logic              pend_q,
    output logic              ovr_q
);
    typedef struct packed {
        logic [DATA_W-1:0] key;
        logic              pend;
        logic              ovr;
    } kl_state_t;

    kl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_key)  st_d.pend = 1'b0;
        if (clr_stat) st_d.ovr  = 1'b0;
        if (stb) begin
            st_d.key  = code;
            st_d.pend = 1'b1;
            if (st_q.pend && !clr_key) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key_q  = st_q.key;
    assign pend_q = st_q.pend;
    assign ovr_q  = st_q.ovr;

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (key_q == $past(code)) && pend_q);

    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_key && !stb) |=> !pend_q);

    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && pend_q && !clr_key) |=> ovr_q);

    assert_race_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && clr_key && !ovr_q) |=> !ovr_q);

    assert_stat_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stat && !stb) |=> !ovr_q && (pend_q == $past(pend_q && !clr_key)));
endmodule

// File: rtl/mmio_timer.sv
module mmio_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [TIMER_W-1:0] cnt_q
);
    logic [TIMER_W-1:0] cnt_d;

    always_comb cnt_d = cnt_q + TIMER_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cnt_q == $past(cnt_q) + TIMER_W'(1));
endmodule

// File: rtl/mmio_periph.sv
module mmio_periph
    import mmio_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WIN_BITS = 7,
    parameter logic [ADDR_W-1:0] BASE = 16'hD000,
    parameter int TIMER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rw,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rd_en,
    input  logic              key_stb,
    input  logic [DATA_W-1:0] key_code,
    output logic [DATA_W-1:0] led_out,
    output logic              irq_n
);
    logic               hit;
    reg_sel_e           sel;
    logic [DATA_W-1:0]  key_q;
    logic               pend_q, ovr_q;
    logic [TIMER_W-1:0] tmr_q;
    logic [TIMER_W-1:0] tmr_hi;
    logic               rd_cyc, led_wr;
    logic [DATA_W-1:0]  led_d, led_q;

    mmio_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE(BASE)) u_decode (
        .addr (bus_addr),
        .hit  (hit),
        .sel  (sel)
    );

    assign rd_cyc = hit && bus_rw;
    assign led_wr = hit && !bus_rw && (sel == SEL_LED);

    mmio_keylatch #(.DATA_W(DATA_W)) u_keylatch (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (key_stb),
        .code     (key_code),
        .clr_key  (rd_cyc && (sel == SEL_KEY)),
        .clr_stat (rd_cyc && (sel == SEL_STAT)),
        .key_q    (key_q),
        .pend_q   (pend_q),
        .ovr_q    (ovr_q)
    );

    mmio_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_q (tmr_q)
    );

    assign tmr_hi = tmr_q >> DATA_W;

    always_comb begin
        led_d = led_q;
        if (led_wr) led_d = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) led_q <= '0;
        else        led_q <= led_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_cyc) begin
            case (sel)
                SEL_LED:  bus_rdata = led_q;
                SEL_KEY:  bus_rdata = key_q;
                SEL_STAT: bus_rdata = DATA_W'({ovr_q, pend_q});
                SEL_TLO:  bus_rdata = tmr_q[DATA_W-1:0];
                SEL_THI:  bus_rdata = tmr_hi[DATA_W-1:0];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign bus_rd_en = rd_cyc;
    assign led_out   = led_q;
    assign irq_n     = !pend_q;

    assert_led_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        led_wr |=> led_out == $past(bus_wdata));

    assert_led_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !led_wr |=> $stable(led_out));

    assert_rd_en_only_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rw |-> !bus_rd_en);

    assert_irq_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        key_stb |=> !irq_n);
endmodule

// File: tb/mmio_periph_bench.sv
module mmio_periph_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rw = 1'b1;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rd_en;
    logic        key_stb = 1'b0;
    logic [7:0]  key_code = '0;
    logic [7:0]  led_out;
    logic        irq_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] cyc;
    logic [7:0]  s_rd, s_led;
    logic        s_en, s_irq;
    logic [15:0] s_cyc;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_periph u_mmio_periph (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rw    (bus_rw),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rd_en (bus_rd_en),
        .key_stb   (key_stb),
        .key_code  (key_code),
        .led_out   (led_out),
        .irq_n     (irq_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + 16'd1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic rw, input logic [7:0] wd,
                        input logic stb, input logic [7:0] code);
        @(negedge clk);
        bus_addr = a; bus_rw = rw; bus_wdata = wd; key_stb = stb; key_code = code;
        #1;
        s_rd = bus_rdata; s_en = bus_rd_en; s_irq = irq_n; s_led = led_out; s_cyc = cyc;
    endtask

    task automatic idle();
        step(16'h0000, 1'b1, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic rd(input logic [15:0] a);
        step(a, 1'b1, 8'h00, 1'b0, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (250000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] exp_led;
        logic [7:0] first_lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        idle();
        check("R10 irq_n after reset", s_irq, 1);
        check("R10 led after reset", s_led, 0);
        check("R10 timer after reset", s_cyc < 16'd4, 1);
        rd(16'hD013);
        check("R10 status after reset", s_rd, 8'h00);
        rd(16'hD012);
        check("R10 key after reset", s_rd, 8'h00);

        // R1, R11, R9, R3: full read sweep of the address space
        for (int a = 0; a < 65536; a++) begin
            logic in_win;
            logic [7:0] exp_rd;
            rd(a[15:0]);
            in_win = (a >= 'hD000) && (a <= 'hD07F);
            check("R1 read enable decode", s_en, in_win);
            exp_rd = 8'h00;
            if (in_win) begin
                case (a & 'h7F)
                    'h40: exp_rd = s_cyc[7:0];
                    'h41: exp_rd = s_cyc[15:8];
                    default: exp_rd = 8'h00;
                endcase
                check("R11/R9/R3 window read data", s_rd, exp_rd);
            end
        end

        // R2, R1: write sweep, only 0xD000 reaches the LEDs
        exp_led = 8'h00;
        for (int a = 'hC000; a < 'hE000; a++) begin
            logic [7:0] wd;
            wd = a[15:8] ^ a[7:0] ^ 8'h3C;
            step(a[15:0], 1'b0, wd, 1'b0, 8'h00);
            check("R2 led tracks writes", s_led, exp_led);
            check("R1 no drive on write", s_en, 0);
            if (a == 'hD000) exp_led = wd;
        end
        idle();
        check("R2 led after sweep", s_led, exp_led);
        rd(16'hD012);
        check("R2 key unaffected by writes", s_rd, 8'h00);
        rd(16'hD013);
        check("R2 status unaffected by writes", s_rd, 8'h00);

        // R2, R3: every LED value
        for (int v = 0; v < 256; v++) begin
            step(16'hD000, 1'b0, v[7:0], 1'b0, 8'h00);
            rd(16'hD000);
            check("R2 led pins", s_led, v[7:0]);
            check("R3 led readback", s_rd, v[7:0]);
        end
        step(16'hD000, 1'b0, 8'hA5, 1'b0, 8'h00);
        idle();
        check("R2 pattern lights 7,5,2,0", {s_led[7], s_led[5], s_led[2], s_led[0]}, 4'hF);
        check("R2 pattern others dark", {s_led[6], s_led[4], s_led[3], s_led[1]}, 4'h0);

        // R4, R5: single key event
        step(16'h0000, 1'b1, 8'h00, 1'b1, 8'h41);
        check("R5 irq high during strobe cycle", s_irq, 1);
        idle();
        check("R5 irq low after event", s_irq, 0);
        idle();
        check("R5 irq held low", s_irq, 0);
        rd(16'hD013);
        check("R7 status pending only", s_rd, 8'h01);
        rd(16'hD012);
        check("R4 key code read", s_rd, 8'h41);
        check("R5 irq still low in read cycle", s_irq, 0);
        idle();
        check("R5 irq released after read", s_irq, 1);
        rd(16'hD013);
        check("R7 status clear after read", s_rd, 8'h00);

        // R6, R7: overrun
        step(16'h0000, 1'b1, 8'h00, 1'b1, 8'h10);
        step(16'h0000, 1'b1, 8'h00, 1'b1, 8'h22);
        rd(16'hD013);
        check("R6 overrun and pending", s_rd, 8'h03);
        rd(16'hD013);
        check("R7 overrun cleared by status read", s_rd, 8'h01);
        check("R7 irq unchanged by status read", s_irq, 0);
        rd(16'hD012);
        check("R6 newest code kept", s_rd, 8'h22);
        idle();
        check("R5 irq released", s_irq, 1);

        // R8: event and data read in the same cycle
        step(16'h0000, 1'b1, 8'h00, 1'b1, 8'h30);
        step(16'hD012, 1'b1, 8'h00, 1'b1, 8'h31);
        check("R8 read returns old code", s_rd, 8'h30);
        idle();
        check("R8 irq stays low", s_irq, 0);
        rd(16'hD013);
        check("R8 pending without overrun", s_rd, 8'h01);
        rd(16'hD012);
        check("R8 new code kept", s_rd, 8'h31);
        idle();
        check("R8 irq released", s_irq, 1);

        // R9: consecutive reads and wrap
        rd(16'hD040);
        first_lo = s_rd;
        rd(16'hD040);
        check("R9 consecutive low reads differ by one", s_rd, first_lo + 8'd1);
        check("R9 low byte matches count", s_rd, s_cyc[7:0]);
        while (s_cyc != 16'hFFFD) idle();
        rd(16'hD041);
        check("R9 high byte before wrap", s_rd, 8'hFF);
        rd(16'hD040);
        check("R9 low byte before wrap", s_rd, 8'hFF);
        rd(16'hD041);
        check("R9 high byte after wrap", s_rd, 8'h00);
        rd(16'hD040);
        check("R9 low byte after wrap", s_rd, 8'h01);

        finish_run();
    end
endmodule